// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a 1 KB direct-mapped data cache placed between a processor request port and a lower-level memory port. It holds 32 lines of 32 bytes, each with a tag, a valid flag and a dirty flag. The processor presents one 32-bit word access at a time and holds it until the cache answers with ready. Hits are served in the cycle they are presented. Misses stall the processor while a small controller moves whole lines over a one-word-per-handshake memory port.

Writes that hit only modify the cached line and mark it dirty. When a line is replaced, it is copied back to memory first if it is dirty; a clean line is simply overwritten. A static configuration input selects how write misses are handled. In allocate mode the line is fetched and then written. In non-allocate mode the single word goes straight to memory and the cache is left untouched. Two counters expose the number of requests that hit and that missed.

Top module: `dmc_cache`

## Requirements
- R1: A request address is decoded as tag = bits 31..10, line index = bits 9..5 and word within the line = bits 4..2. Bits 1..0 are ignored.
- R2: A request hits when the indexed line is valid and its stored tag equals the request tag. A hit raises `cpu_req_ready` combinationally in the cycle the request is presented. For a read, `cpu_rsp_rdata` carries the word in that same cycle.
- R3: A write hit updates only the cached word and marks the line dirty, with no memory traffic.
- R4: On a miss, `cpu_req_ready` stays low until the request completes. A refill reads 8 words, one per accepted memory handshake, at ascending word offsets 0..7 of the line base.
- R5: Before a refill, a valid dirty victim is written back as 8 word writes at the victim's own address. A clean or invalid victim causes no memory write.
- R6: With `cfg_wr_alloc` = 1, a write miss refills the line, then writes the word into the cache and marks the line dirty.
- R7: With `cfg_wr_alloc` = 0, a write miss performs exactly one memory write of the word to its address and leaves the cache contents and flags unchanged. The input may change between requests.
- R8: `hit_count` counts requests that hit on their first lookup, and `miss_count` counts requests that missed. On an empty cache, write A, write A, read B, write B, write A (A and B in different lines) yields 1 hit and 4 misses without allocation, and 3 hits and 2 misses with allocation.
- R9: A synchronous reset clears every valid and dirty flag and both counters. Dirty data held at reset is discarded, and the first access to any line afterwards misses.
- R10: While a memory request is not accepted, its valid, direction, address and write data hold stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_alloc | input | 1 | 1 = write-allocate, 0 = no-write-allocate on write misses |
| cpu_req_valid | input | 1 | Processor request present; held until ready |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address of the word |
| cpu_req_wdata | input | 32 | Write data |
| cpu_req_ready | output | 1 | Request completes in this cycle |
| cpu_rsp_rdata | output | 32 | Read data, valid with ready on a read |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | 32 | Word-aligned memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_req_ready | input | 1 | Memory accepts the request in this cycle |
| mem_rsp_rdata | input | 32 | Read data, valid in the accepting cycle of a read |
| hit_count | output | 16 | Requests that hit |
| miss_count | output | 16 | Requests that missed |

## Verification
The bench builds the block with its default geometry: 32-bit words and addresses, 32 lines of 32 bytes and 16-bit counters. Addresses stay under 4 KB, so only four tag values meet across a handful of lines. This keeps conflict evictions, dirty write-backs and clean drops frequent in a short random run. The memory's ready toggles in a fixed stall pattern, so every beat of a refill or write-back also sees held requests. The allocate setting is flipped between requests, which brings both write-miss paths and their mixing on the same lines within reach.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    // Controller states: lookup, victim copy-out, line fetch,
    // single-word write-through on a non-allocating write miss, completion.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WBACK  = 3'd1,
        ST_FILL   = 3'd2,
        ST_BYPASS = 3'd3,
        ST_FINISH = 3'd4
    } ctrl_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int TAG_W     = 22,
    parameter int IDX_W     = 5,
    parameter int NUM_LINES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);

    logic [NUM_LINES-1:0] valid_d, valid_q;
    logic [NUM_LINES-1:0] dirty_d, dirty_q;
    logic [TAG_W-1:0]     tags_q [NUM_LINES];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (fill_en) begin
            valid_d[idx] = 1'b1;
            dirty_d[idx] = 1'b0;
        end else if (mark_dirty) begin
            dirty_d[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tags_q[idx] <= fill_tag;
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tags_q[idx];

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int WSEL_W = 3
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WSEL_W-1:0] sel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = (1 << IDX_W) * (1 << WSEL_W);

    logic [DATA_W-1:0] words_q [DEPTH];
    logic [IDX_W+WSEL_W-1:0] flat_addr;

    assign flat_addr = {idx, sel};

    always_ff @(posedge clk) begin
        if (we) begin
            words_q[flat_addr] <= wdata;
        end
    end

    assign rdata = words_q[flat_addr];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 22,
    parameter int IDX_W  = 5,
    parameter int WSEL_W = 3,
    parameter int BOFF_W = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_alloc,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [WSEL_W-1:0] req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              line_valid,
    input  logic              line_dirty,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] word_rdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              req_ready,
    output logic [WSEL_W-1:0] word_sel,
    output logic              data_we,
    output logic [DATA_W-1:0] data_wdata,
    output logic              fill_en,
    output logic              mark_dirty,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    typedef struct packed {
        ctrl_state_e       st;
        logic [WSEL_W-1:0] beat;
        logic              retry;
        logic [CNT_W-1:0]  hits;
        logic [CNT_W-1:0]  misses;
    } ctrl_regs_t;

    localparam logic [BOFF_W-1:0] BOFF_ZERO = '0;
    localparam ctrl_regs_t REGS_RESET = '{
        st: ST_IDLE, beat: '0, retry: 1'b0, hits: '0, misses: '0
    };

    ctrl_regs_t r_d, r_q;
    logic       tag_hit;
    logic       last_beat;

    assign tag_hit   = line_valid && (line_tag == req_tag);
    assign last_beat = &r_q.beat;

    always_comb begin
        r_d        = r_q;
        req_ready  = 1'b0;
        data_we    = 1'b0;
        data_wdata = req_wdata;
        fill_en    = 1'b0;
        mark_dirty = 1'b0;
        mem_valid  = 1'b0;
        mem_write  = 1'b0;
        mem_addr   = {req_tag, req_idx, req_sel, BOFF_ZERO};
        mem_wdata  = req_wdata;
        word_sel   = (r_q.st == ST_IDLE) ? req_sel : r_q.beat;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (tag_hit) begin
                        req_ready = 1'b1;
                        r_d.retry = 1'b0;
                        if (!r_q.retry) begin
                            r_d.hits = r_q.hits + 1'b1;
                        end
                        if (req_write) begin
                            data_we    = 1'b1;
                            mark_dirty = 1'b1;
                        end
                    end else begin
                        r_d.misses = r_q.misses + 1'b1;
                        r_d.beat   = '0;
                        if (req_write && !cfg_wr_alloc) begin
                            r_d.st = ST_BYPASS;
                        end else if (line_valid && line_dirty) begin
                            r_d.st = ST_WBACK;
                        end else begin
                            r_d.st = ST_FILL;
                        end
                    end
                end
            end
            ST_WBACK: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {line_tag, req_idx, r_q.beat, BOFF_ZERO};
                mem_wdata = word_rdata;
                if (mem_ready) begin
                    r_d.beat = r_q.beat + 1'b1;
                    if (last_beat) begin
                        r_d.st = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {req_tag, req_idx, r_q.beat, BOFF_ZERO};
                if (mem_ready) begin
                    data_we    = 1'b1;
                    data_wdata = mem_rdata;
                    r_d.beat   = r_q.beat + 1'b1;
                    if (last_beat) begin
                        fill_en   = 1'b1;
                        r_d.st    = ST_IDLE;
                        r_d.retry = 1'b1;
                    end
                end
            end
            ST_BYPASS: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                if (mem_ready) begin
                    r_d.st = ST_FINISH;
                end
            end
            ST_FINISH: begin
                req_ready = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign hit_count  = r_q.hits;
    assign miss_count = r_q.misses;

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 32,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_alloc,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BOFF_W     = $clog2(WORD_BYTES);
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int TAG_W      = ADDR_W - IDX_W - WSEL_W - BOFF_W;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_sel;
    logic              line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [WSEL_W-1:0] word_sel;
    logic              data_we;
    logic [DATA_W-1:0] data_wdata, word_rdata;
    logic              fill_en, mark_dirty;

    assign req_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = cpu_req_addr[BOFF_W+WSEL_W +: IDX_W];
    assign req_sel = cpu_req_addr[BOFF_W +: WSEL_W];

    dmc_tag_store #(
        .TAG_W(TAG_W), .IDX_W(IDX_W), .NUM_LINES(NUM_LINES)
    ) u_tags (
        .clk(clk), .rst(rst), .idx(req_idx),
        .fill_en(fill_en), .fill_tag(req_tag), .mark_dirty(mark_dirty),
        .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag)
    );

    dmc_data_store #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) u_data (
        .clk(clk), .idx(req_idx), .sel(word_sel),
        .we(data_we), .wdata(data_wdata), .rdata(word_rdata)
    );

    dmc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W),
        .WSEL_W(WSEL_W), .BOFF_W(BOFF_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .cfg_wr_alloc(cfg_wr_alloc),
        .req_valid(cpu_req_valid), .req_write(cpu_req_write),
        .req_tag(req_tag), .req_idx(req_idx), .req_sel(req_sel),
        .req_wdata(cpu_req_wdata),
        .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag),
        .word_rdata(word_rdata),
        .mem_ready(mem_req_ready), .mem_rdata(mem_rsp_rdata),
        .req_ready(cpu_req_ready), .word_sel(word_sel),
        .data_we(data_we), .data_wdata(data_wdata),
        .fill_en(fill_en), .mark_dirty(mark_dirty),
        .mem_valid(mem_req_valid), .mem_write(mem_req_write),
        .mem_addr(mem_req_addr), .mem_wdata(mem_req_wdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    assign cpu_rsp_rdata = word_rdata;

endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);

    // R2: completion only answers a presented request
    p_ready_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_req_ready |-> cpu_req_valid);

    // R4: the processor is stalled whenever memory traffic is in flight
    p_stall_while_mem_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !cpu_req_ready);

    // R4: a newly counted miss is never completed in the following cycle
    p_miss_stalls_r4: assert property (@(posedge clk) disable iff (rst)
        (miss_count != $past(miss_count)) |-> !cpu_req_ready);

    // R10: an unaccepted memory request is held
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_write) &&
             $stable(mem_req_addr) && $stable(mem_req_wdata)));

    // R8: the hit counter advances by at most one per cycle
    p_hit_step_r8: assert property (@(posedge clk) disable iff (rst)
        (hit_count - $past(hit_count)) <= CNT_W'(1));

    // R9: leaving reset, both counters read zero
    p_reset_clears_r9: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (hit_count == '0 && miss_count == '0));

endmodule

bind dmc_cache dmc_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/dmc_cache_tb.sv
module dmc_cache_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_alloc = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_write = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_req_ready;
    logic [31:0] cpu_rsp_rdata;
    logic        mem_req_valid, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_rsp_rdata;
    logic [15:0] hit_count, miss_count;

    always #10 clk = ~clk;   // 50 MHz

    dmc_cache u_dut (
        .clk(clk), .rst(rst), .cfg_wr_alloc(cfg_wr_alloc),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rsp_rdata(mem_rsp_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // Behavioural lower memory (4 KB window) and architectural image
    logic [31:0] mem_words [0:1023];
    logic [31:0] gold      [0:1023];
    // Behavioural cache bookkeeping
    bit          mv [0:31];
    bit          md [0:31];
    int          mt [0:31];

    int checks = 0, fails = 0;
    int exp_hits = 0, exp_misses = 0;
    int wr_beats = 0, rd_beats = 0, rdy_cnt = 0;

    assign mem_rsp_rdata = mem_words[mem_req_addr[11:2]];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory ready stalls on a fixed pattern
    always @(negedge clk) begin
        rdy_cnt <= rdy_cnt + 1;
        mem_req_ready <= (rdy_cnt % 5) != 2;
    end

    // Memory side: perform accepted beats, check refill ordering (R4)
    always @(posedge clk) begin
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem_words[mem_req_addr[11:2]] <= mem_req_wdata;
                wr_beats++;
            end else begin
                chk("R4", "refill beat offset", {29'd0, mem_req_addr[4:2]},
                    {29'd0, rd_beats[2:0]});
                rd_beats++;
            end
        end
    end

    // Every clock: no memory traffic or completion without a request (R4)
    always begin
        @(negedge clk);
        #6;
        if (!rst && !cpu_req_valid) begin
            chk("R4", "idle mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
            chk("R2", "idle cpu_req_ready", {31'd0, cpu_req_ready}, 32'd0);
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; end
        for (int i = 0; i < 1024; i++) gold[i] = mem_words[i];  // R9 dirty data dropped
        exp_hits = 0;
        exp_misses = 0;
        #6;
        chk("R9", "hit_count after reset", {16'd0, hit_count}, 32'd0);
        chk("R9", "miss_count after reset", {16'd0, miss_count}, 32'd0);
    endtask

    task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd);
        int  idx = int'(addr[9:5]);
        int  tg  = int'(addr[31:10]);
        int  w   = int'(addr[11:2]);
        bit  hit = mv[idx] && (mt[idx] == tg);
        bit  bypass = !hit && wr && !cfg_wr_alloc;
        bit  evict  = !hit && !bypass && mv[idx] && md[idx];
        int  vbase  = (mt[idx] * 256) + (idx * 8);
        int  lat = 0;
        logic [31:0] rd;
        @(negedge clk);
        wr_beats = 0;
        rd_beats = 0;
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = addr;
        cpu_req_wdata = wd;
        #5;
        while (!cpu_req_ready) begin
            @(negedge clk);
            #5;
            lat++;
        end
        rd = cpu_rsp_rdata;
        if (hit) chk("R2", "hit latency", lat, 0);
        else if (lat == 0) chk("R4", "miss must stall", 1, 0);
        if (!wr) chk("R2", "read data", rd, gold[w]);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (wr) gold[w] = wd;
        if (hit) begin
            exp_hits++;
            if (wr) md[idx] = 1;
        end else begin
            exp_misses++;
            if (!bypass) begin mv[idx] = 1; mt[idx] = tg; md[idx] = wr; end
        end
        #1;
        chk("R8", "hit_count", {16'd0, hit_count}, exp_hits);
        chk("R8", "miss_count", {16'd0, miss_count}, exp_misses);
        chk(bypass ? "R7" : (evict ? "R5" : "R3"), "write beats",
            wr_beats, bypass ? 1 : (evict ? 8 : 0));
        chk(wr && !bypass && !hit ? "R6" : "R4", "read beats",
            rd_beats, (hit || bypass) ? 0 : 8);
        if (bypass) chk("R7", "word written through", mem_words[w], wd);
        if (evict)
            for (int k = 0; k < 8; k++)
                chk("R5", "victim word in memory", mem_words[vbase + k], gold[vbase + k]);
    endtask

    task automatic ref_sequence(input bit alloc, input int eh, input int em);
        cfg_wr_alloc = alloc;
        do_reset();
        access(1, 32'h100, 32'hA1A1_0001);
        access(1, 32'h100, 32'hA1A1_0002);
        access(0, 32'h200, 32'h0);
        access(1, 32'h200, 32'hB2B2_0003);
        access(1, 32'h100, 32'hA1A1_0004);
        chk("R8", alloc ? "alloc hits" : "no-alloc hits", {16'd0, hit_count}, eh);
        chk("R8", alloc ? "alloc misses" : "no-alloc misses", {16'd0, miss_count}, em);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem_words[i] = (i * 32'h0101_0107) ^ 32'h5A00_0000;
        do_reset();
        chk("R9", "ready idle after reset", {31'd0, cpu_req_ready}, 32'd0);
        chk("R9", "mem idle after reset", {31'd0, mem_req_valid}, 32'd0);

        ref_sequence(1'b0, 1, 4);   // R7 R8
        ref_sequence(1'b1, 3, 2);   // R6 R8

        // R5: dirty line 0x100 evicted by 0x500 (same index), then clean drop
        access(1, 32'h104, 32'hDEAD_0005);
        access(0, 32'h500, 32'h0);
        access(0, 32'h104, 32'h0);
        // R1: low byte bits ignored
        access(0, 32'h107, 32'h0);

        // Mixed traffic over four tags and four lines, policy flipped
        for (int n = 0; n < 320; n++) begin
            logic [31:0] a;
            if (n % 40 == 0) cfg_wr_alloc = ~cfg_wr_alloc;
            a = ({30'd0, 2'($urandom)} << 10) | ({30'd0, 2'($urandom)} << 5) |
                ({29'd0, 3'($urandom)} << 2);
            access(1'($urandom), a, $urandom);
        end

        // R9: reset mid-run discards state; first accesses miss again
        do_reset();
        access(0, 32'h104, 32'h0);
        access(0, 32'h104, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule